// File: doc/BRIEF.md
# Multi-Mode Link Indicator Controller

This block drives three status lamps for a network port. Each lamp picks one of sixteen status sources through a 4-bit selector. The sources cover link speed, duplex, collisions, traffic, the bus width and transmit flow control, plus fixed on and off. A lamp can blink while its source is true. Its pin can be active-low or active-high.

All lamps share one blink timebase, clocked by a millisecond tick, so blinking lamps stay in phase. One global bit sets the half-period to either a slow or a fast value. Short traffic and collision pulses pass through a retriggerable hold timer, so that a single-cycle event still gives a visible flash.

Configuration arrives as one wide word, loaded on a write strobe. Every field has a reset default, and every output pin is registered.

Top module: `led_indicator_ctrl`

## Requirements
- R1: After reset, every pin is at its inactive level (1). The reset configuration is lamp 0 on selector 0100b with blink on, lamp 1 on 0111b and lamp 2 on 0110b, both with blink off. All lamps have invert 0, and the global rate bit is 0. The blink timebase starts in its off phase.
- R2: The speed selectors are true only while `link_up` is 1: 0000b (10 or 1000 Mb/s), 0001b (100 or 1000 Mb/s), 0010b (any speed), 0101b (10 only), 0110b (100 only) and 0111b (1000 only).
- R3: The level selectors follow their input directly, without regard to link: 1001b follows `full_duplex`, 1100b follows `single_lane` and 1101b follows `tx_paused`.
- R4: Let activity be a stretched `tx_activity` OR `rx_activity`. Selector 1011b is link AND activity. Selector 0011b is link AND a stretched `filtered_activity`. Selector 0100b is link AND NOT activity. Selector 1010b is a stretched `collision`.
- R5: Each stretched source is true in any cycle where its raw input is 1. The timer is then reloaded to HOLD_MS, and each `ms_tick` counts it down by one. The source stays true while the count is nonzero, so it lasts until the HOLD_MS-th tick after the last pulse. A new pulse restarts the count.
- R6: Selector 1110b is always true. Selectors 1111b and 1000b (reserved) are always false.
- R7: With invert 0 an asserted lamp drives its pin to 0; with invert 1 it drives 1. A lamp that is not asserted drives the opposite level.
- R8: With blink 1, a lamp is asserted only when its source is true and the shared phase is on. The phase flips after every half-period of ticks, starting off after reset. A false source keeps the pin inactive.
- R9: Global rate bit 0 selects a half-period of SLOW_HALF_MS ticks and 1 selects FAST_HALF_MS ticks, for all lamps together.
- R10: A `cfg_we` pulse loads `cfg_wdata` in the clock edge where it is sampled. Lamp i uses bits [6i+3:6i] as the selector, bit 6i+4 as invert and bit 6i+5 as blink. The top bit is the global rate. Each pin shows, one clock later, the status inputs and configuration sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| link_up | input | 1 | Link established |
| speed_10 | input | 1 | Link runs at 10 Mb/s |
| speed_100 | input | 1 | Link runs at 100 Mb/s |
| speed_1000 | input | 1 | Link runs at 1000 Mb/s |
| full_duplex | input | 1 | Full-duplex operation |
| collision | input | 1 | Collision event pulse |
| tx_activity | input | 1 | Transmit traffic pulse |
| rx_activity | input | 1 | Receive traffic pulse |
| filtered_activity | input | 1 | Traffic that passed address filtering |
| single_lane | input | 1 | One-lane bus connection detected |
| tx_paused | input | 1 | Transmitter held by flow control |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_wdata | input | NUM_LED*6+1 | Configuration word |
| led_pin | output | NUM_LED | Lamp pins |

## Verification
The bench builds the block with SLOW_HALF_MS=5, FAST_HALF_MS=2 and HOLD_MS=3, which keeps the cycle count small. With these values, whole blink periods at both rates can be stepped tick by tick, and a stretcher can be watched until it expires and after it is retriggered. At this size the bench also sweeps all sixteen selectors against 64 status patterns, with all three lamps on the same selector but with different invert settings.

// File: rtl/led_ind_pkg.sv
package led_ind_pkg;

  localparam int SLOT_W = 6;

  typedef enum logic [3:0] {
    SRC_SPD_10_G  = 4'h0,
    SRC_SPD_100_G = 4'h1,
    SRC_LINK      = 4'h2,
    SRC_FILT      = 4'h3,
    SRC_LINK_IDLE = 4'h4,
    SRC_SPD_10    = 4'h5,
    SRC_SPD_100   = 4'h6,
    SRC_SPD_1G    = 4'h7,
    SRC_RSVD      = 4'h8,
    SRC_FDX       = 4'h9,
    SRC_COLL      = 4'hA,
    SRC_ACT       = 4'hB,
    SRC_ONE_LANE  = 4'hC,
    SRC_PAUSED    = 4'hD,
    SRC_ON        = 4'hE,
    SRC_OFF       = 4'hF
  } src_sel_e;

  typedef struct packed {
    logic     blink;
    logic     inv;
    src_sel_e mode;
  } lane_cfg_t;

  typedef struct packed {
    logic link;
    logic s10;
    logic s100;
    logic s1000;
    logic fdx;
    logic coll;
    logic act;
    logic filt;
    logic one_lane;
    logic paused;
  } lane_stat_t;

  function automatic lane_cfg_t lane_default(input int idx);
    lane_cfg_t c;
    c.inv = 1'b0;
    case (idx)
      0: begin c.mode = SRC_LINK_IDLE; c.blink = 1'b1; end
      1: begin c.mode = SRC_SPD_1G;    c.blink = 1'b0; end
      default: begin c.mode = SRC_SPD_100; c.blink = 1'b0; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/led_blink_base.sv
module led_blink_base #(
  parameter int SLOW_HALF_MS = 200,
  parameter int FAST_HALF_MS = 83
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic fast_i,
  output logic phase_o
);
  localparam int MAXH = (SLOW_HALF_MS > FAST_HALF_MS) ? SLOW_HALF_MS : FAST_HALF_MS;
  localparam int CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          phase_q;

  assign lim = fast_i ? CW'(FAST_HALF_MS - 1) : CW'(SLOW_HALF_MS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q >= lim) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(MAXH));

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(phase_q));

endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int HOLD_MS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic pulse_i,
  output logic busy_o
);
  localparam int HW = $clog2(HOLD_MS + 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (pulse_i) begin
      cnt_q <= HW'(HOLD_MS);
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = pulse_i | (cnt_q != '0);

  // R5
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_i |=> busy_o);

  // R5
  hold_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= HW'(HOLD_MS));

endmodule

// File: rtl/led_lane.sv
module led_lane
  import led_ind_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lane_cfg_t  cfg_i,
  input  lane_stat_t st_i,
  input  logic       phase_i,
  output logic       pin_o
);
  logic src;
  logic on;
  logic pin_q;

  always_comb begin
    case (cfg_i.mode)
      SRC_SPD_10_G:  src = st_i.link & (st_i.s10 | st_i.s1000);
      SRC_SPD_100_G: src = st_i.link & (st_i.s100 | st_i.s1000);
      SRC_LINK:      src = st_i.link;
      SRC_FILT:      src = st_i.link & st_i.filt;
      SRC_LINK_IDLE: src = st_i.link & ~st_i.act;
      SRC_SPD_10:    src = st_i.link & st_i.s10;
      SRC_SPD_100:   src = st_i.link & st_i.s100;
      SRC_SPD_1G:    src = st_i.link & st_i.s1000;
      SRC_FDX:       src = st_i.fdx;
      SRC_COLL:      src = st_i.coll;
      SRC_ACT:       src = st_i.link & st_i.act;
      SRC_ONE_LANE:  src = st_i.one_lane;
      SRC_PAUSED:    src = st_i.paused;
      SRC_ON:        src = 1'b1;
      default:       src = 1'b0;
    endcase
  end

  assign on = src & (~cfg_i.blink | phase_i);

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b1;
    else     pin_q <= cfg_i.inv ? on : ~on;
  end

  assign pin_o = pin_q;

  // R6
  off_mode_chk: assert property (@(posedge clk) disable iff (rst)
    ((cfg_i.mode == SRC_OFF || cfg_i.mode == SRC_RSVD) && !cfg_i.inv) |=> pin_q);

  // R6
  on_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.mode == SRC_ON && !cfg_i.blink && cfg_i.inv) |=> pin_q);

  // R8
  blink_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.blink && !phase_i && !cfg_i.inv) |=> pin_q);

endmodule

// File: rtl/led_indicator_ctrl.sv
module led_indicator_ctrl
  import led_ind_pkg::*;
#(
  parameter int NUM_LED      = 3,
  parameter int SLOW_HALF_MS = 200,
  parameter int FAST_HALF_MS = 83,
  parameter int HOLD_MS      = 50,
  localparam int CFG_W       = NUM_LED * SLOT_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ms_tick,
  input  logic               link_up,
  input  logic               speed_10,
  input  logic               speed_100,
  input  logic               speed_1000,
  input  logic               full_duplex,
  input  logic               collision,
  input  logic               tx_activity,
  input  logic               rx_activity,
  input  logic               filtered_activity,
  input  logic               single_lane,
  input  logic               tx_paused,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [NUM_LED-1:0] led_pin
);
  lane_cfg_t  cfg_q [NUM_LED];
  logic       rate_q;
  logic       phase;
  logic       act_busy, filt_busy, coll_busy;
  lane_stat_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= 1'b0;
      for (int i = 0; i < NUM_LED; i++) cfg_q[i] <= lane_default(i);
    end else if (cfg_we) begin
      rate_q <= cfg_wdata[CFG_W-1];
      for (int i = 0; i < NUM_LED; i++)
        cfg_q[i] <= lane_cfg_t'(cfg_wdata[i*SLOT_W +: SLOT_W]);
    end
  end

  led_blink_base #(
    .SLOW_HALF_MS(SLOW_HALF_MS),
    .FAST_HALF_MS(FAST_HALF_MS)
  ) i_base (
    .clk(clk), .rst(rst), .tick_i(ms_tick), .fast_i(rate_q), .phase_o(phase)
  );

  led_stretch #(.HOLD_MS(HOLD_MS)) i_act_hold (
    .clk(clk), .rst(rst), .tick_i(ms_tick),
    .pulse_i(tx_activity | rx_activity), .busy_o(act_busy)
  );

  led_stretch #(.HOLD_MS(HOLD_MS)) i_filt_hold (
    .clk(clk), .rst(rst), .tick_i(ms_tick),
    .pulse_i(filtered_activity), .busy_o(filt_busy)
  );

  led_stretch #(.HOLD_MS(HOLD_MS)) i_coll_hold (
    .clk(clk), .rst(rst), .tick_i(ms_tick),
    .pulse_i(collision), .busy_o(coll_busy)
  );

  always_comb begin
    st.link     = link_up;
    st.s10      = speed_10;
    st.s100     = speed_100;
    st.s1000    = speed_1000;
    st.fdx      = full_duplex;
    st.coll     = coll_busy;
    st.act      = act_busy;
    st.filt     = filt_busy;
    st.one_lane = single_lane;
    st.paused   = tx_paused;
  end

  for (genvar g = 0; g < NUM_LED; g++) begin : g_lane
    led_lane i_lane (
      .clk(clk), .rst(rst), .cfg_i(cfg_q[g]), .st_i(st),
      .phase_i(phase), .pin_o(led_pin[g])
    );
  end

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!link_up && !full_duplex && !single_lane && !tx_paused && !coll_busy &&
     cfg_q[0].mode != SRC_ON && !cfg_q[0].inv) |=> led_pin[0]);

endmodule

// File: tb/test_led_indicator_ctrl.sv
module test_led_indicator_ctrl;
  localparam int NL   = 3;
  localparam int SLOW = 5;
  localparam int FAST = 2;
  localparam int HOLD = 3;
  localparam int CW   = NL * 6 + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 0, link_up = 0, speed_10 = 0, speed_100 = 0, speed_1000 = 0;
  logic full_duplex = 0, collision = 0, tx_activity = 0, rx_activity = 0;
  logic filtered_activity = 0, single_lane = 0, tx_paused = 0, cfg_we = 0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [NL-1:0] led_pin;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  led_indicator_ctrl #(
    .NUM_LED(NL), .SLOW_HALF_MS(SLOW), .FAST_HALF_MS(FAST), .HOLD_MS(HOLD)
  ) i_led_indicator_ctrl (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .link_up(link_up),
    .speed_10(speed_10), .speed_100(speed_100), .speed_1000(speed_1000),
    .full_duplex(full_duplex), .collision(collision), .tx_activity(tx_activity),
    .rx_activity(rx_activity), .filtered_activity(filtered_activity),
    .single_lane(single_lane), .tx_paused(tx_paused), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .led_pin(led_pin)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // status vector: [9]link [8]s10 [7]s100 [6]s1000 [5]fdx [4]coll [3]act [2]filt [1]lane [0]paused
  function automatic logic exp_src(input logic [3:0] m, input logic [9:0] s);
    case (m)
      4'h0: return s[9] & (s[8] | s[6]);
      4'h1: return s[9] & (s[7] | s[6]);
      4'h2: return s[9];
      4'h3: return s[9] & s[2];
      4'h4: return s[9] & ~s[3];
      4'h5: return s[9] & s[8];
      4'h6: return s[9] & s[7];
      4'h7: return s[9] & s[6];
      4'h9: return s[5];
      4'hA: return s[4];
      4'hB: return s[9] & s[3];
      4'hC: return s[1];
      4'hD: return s[0];
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input logic [9:0] s, input logic use_rx);
    link_up = s[9]; speed_10 = s[8]; speed_100 = s[7]; speed_1000 = s[6];
    full_duplex = s[5]; collision = s[4];
    tx_activity = s[3] & ~use_rx; rx_activity = s[3] & use_rx;
    filtered_activity = s[2]; single_lane = s[1]; tx_paused = s[0];
  endtask

  task automatic write_cfg(input logic [CW-1:0] w);
    cfg_wdata = w; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // slot = {blink, inv, mode}
  function automatic logic [CW-1:0] pack(input logic rate,
      input logic [5:0] s2, input logic [5:0] s1, input logic [5:0] s0);
    return {rate, s2, s1, s0};
  endfunction

  task automatic tick();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(10'd0, 1'b0);
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1: all pins inactive after reset
    for (int i = 0; i < NL; i++) chk(led_pin[i], 1'b1, "R1 reset pin");
    // R1: defaults with 1000 Mb/s link
    drive(10'b10_0100_0000, 1'b0);
    @(negedge clk);
    chk(led_pin[0], 1'b1, "R1 lamp0 blink off phase");
    chk(led_pin[1], 1'b0, "R1 lamp1 1000 default");
    chk(led_pin[2], 1'b1, "R1 lamp2 100 default idle");
    drive(10'b10_1000_0000, 1'b0);
    @(negedge clk);
    chk(led_pin[1], 1'b1, "R1 lamp1 off at 100");
    chk(led_pin[2], 1'b0, "R1 lamp2 100 default");
    for (int t = 0; t < SLOW; t++) tick();
    @(negedge clk);
    chk(led_pin[0], 1'b0, "R1 lamp0 default blink on phase");

    // R2 R3 R4 R6 R7: selector sweep, lamp1 inverted
    do_reset();
    for (int m = 0; m < 16; m++) begin
      write_cfg(pack(1'b0, {2'b00, 4'(m)}, {2'b01, 4'(m)}, {2'b00, 4'(m)}));
      for (int p = 0; p < 64; p++) begin
        logic [9:0] v;
        logic e;
        v = 10'((p * 97 + m * 29) & 1023);
        drive(v, p[0]);
        @(negedge clk);
        e = exp_src(4'(m), v);
        chk(led_pin[0], ~e, "R2/R3/R4/R6 sweep lamp0 R7 low");
        chk(led_pin[1],  e, "R2/R3/R4/R6 sweep lamp1 R7 high");
        chk(led_pin[2], ~e, "R2/R3/R4/R6 sweep lamp2");
        drive(10'd0, 1'b0);
        for (int k = 0; k < HOLD; k++) tick();
      end
    end

    // R5: stretch of a single-cycle pulse, then retrigger
    do_reset();
    write_cfg(pack(1'b0, 6'h0A, 6'h03, 6'h0B));
    link_up = 1'b1;
    rx_activity = 1'b1; filtered_activity = 1'b1; collision = 1'b1;
    @(negedge clk);
    rx_activity = 1'b0; filtered_activity = 1'b0; collision = 1'b0;
    chk(led_pin[0], 1'b0, "R5 activity on at pulse");
    for (int n = 1; n <= HOLD; n++) begin
      tick();
      @(negedge clk);
      chk(led_pin[0], (n < HOLD) ? 1'b0 : 1'b1, "R5 activity hold");
      chk(led_pin[1], (n < HOLD) ? 1'b0 : 1'b1, "R5 filtered hold");
      chk(led_pin[2], (n < HOLD) ? 1'b0 : 1'b1, "R5 collision hold");
    end
    tx_activity = 1'b1;
    @(negedge clk);
    tx_activity = 1'b0;
    tick(); tick();
    tx_activity = 1'b1;
    @(negedge clk);
    tx_activity = 1'b0;
    tick(); tick();
    @(negedge clk);
    chk(led_pin[0], 1'b0, "R5 retrigger keeps hold");
    tick();
    @(negedge clk);
    chk(led_pin[0], 1'b1, "R5 retrigger expiry");

    // R10: one-cycle latency from status to pin
    write_cfg(pack(1'b0, 6'h0F, 6'h0F, 6'h09));
    full_duplex = 1'b1;
    #1;
    chk(led_pin[0], 1'b1, "R10 pin not yet changed");
    @(negedge clk);
    chk(led_pin[0], 1'b0, "R10 pin after one edge");
    full_duplex = 1'b0;

    // R8 R9: slow blink, lamp1 inverted, lamp2 off with blink
    do_reset();
    write_cfg(pack(1'b0, 6'h3F, 6'h3E, 6'h2E));
    @(negedge clk);
    chk(led_pin[0], 1'b1, "R8 starts off");
    chk(led_pin[1], 1'b0, "R8 inverted starts off");
    for (int t = 1; t <= 4 * SLOW; t++) begin
      logic ph;
      tick();
      @(negedge clk);
      ph = ((t / SLOW) % 2) == 1;
      chk(led_pin[0], ~ph, "R9 slow blink lamp0");
      chk(led_pin[1],  ph, "R8 slow blink lamp1");
      chk(led_pin[2], 1'b0, "R8 false source stays inactive");
    end

    // R9: fast blink on all lamps
    do_reset();
    write_cfg(pack(1'b1, 6'h2E, 6'h3E, 6'h2E));
    for (int t = 1; t <= 4 * FAST; t++) begin
      logic ph;
      tick();
      @(negedge clk);
      ph = ((t / FAST) % 2) == 1;
      chk(led_pin[0], ~ph, "R9 fast blink lamp0");
      chk(led_pin[1],  ph, "R9 fast blink lamp1");
      chk(led_pin[2], ~ph, "R9 fast blink lamp2");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule